// File: doc/BRIEF.md
# Halfword Load Unit with Prioritised Faults

This block carries out an unsigned 16-bit load for a 32-bit soft processor core. A request brings a base register value, a 16-bit immediate, the destination register index and the two current mode bits: user mode and virtual protected mode. The block adds the base to the sign-extended immediate to form the effective address. It presents that address to an external translation lookup and an external zone-protection check, and their results return in the same cycle. It then decides whether the access faults.

Three faults are checked in a fixed order, and at most one is reported for each access. The first is a missing translation while virtual mode is on. The second is a no-access zone hit while both user mode and virtual mode are on. The third is an odd address. When no fault is found, the block strobes the memory read port once. It returns the 16-bit datum zero-extended into a write to the destination register.

When a fault is found, no register write happens and no memory read is issued. The result carries a cause code and the status flags instead. For the first two faults it also carries the mode-bit update: the current bits are saved and then cleared. The latency is set by a parameter and is one or two cycles. Both ends of the block use a valid/ready handshake.

Top module: `hw_load_unit`

## Requirements
- R1: The effective address is `req_base` plus `req_imm` sign-extended to 32 bits, with wrap-around modulo 2^32. It appears on `mem_addr` for the read and on `chk_addr` for the lookups.
- R2: When the request has `req_virt`=1 and `tlb_hit`=0, the result has `res_exc`=1, `res_cause`=5'b10010 and `res_s`=0.
- R3: When R2 does not apply, and `req_user`=1, `req_virt`=1 and `zone_block`=1, the result has `res_exc`=1, `res_cause`=5'b10000, `res_s`=0 and `res_diz`=1. In every other case `res_diz` is 0.
- R4: When neither R2 nor R3 applies and address bit 0 is 1, the result has `res_exc`=1, `res_cause`=5'b00001, `res_w`=0, `res_s`=0 and `res_rx` equal to the destination index. It also has `res_mode_wr`=0, and `res_user`/`res_virt` equal the request's bits. In every other case `res_rx` is 0.
- R5: When several fault conditions hold at once, only the highest one in the order R2, R3, R4 sets the cause and flags.
- R6: A load without fault gives `res_wr_en`=1, `res_exc`=0, `res_dst` equal to the request index, bits 15:0 of `res_data` equal to `mem_rdata`, and bits 31:16 equal to zero.
- R7: A faulting access gives `res_wr_en`=0 and `res_data`=0, and it never asserts `mem_rd_en`. A `mem_rd_en` pulse is never issued with address bit 0 set. Exactly one pulse is issued for each load without fault.
- R8: On an R2 or R3 fault, `res_mode_wr`=1, `res_user_sv` and `res_virt_sv` carry the request's user and virtual bits, and `res_user`=`res_virt`=0. On any other result, `res_mode_wr`=0 and both saved bits are 0.
- R9: `AREA_MODE`=1 gives a latency of two cycles, and `AREA_MODE`=0 or 2 gives one. A request accepted at clock edge k shows `res_valid` after edge k+latency, unless the result port is stalled.
- R10: While `res_valid`=1 and `res_ready`=0, every result output holds its value. Results leave in the order the requests were accepted, and none is lost or repeated.
- R11: During reset `res_valid` and `mem_rd_en` are 0. After reset `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at the next edge when valid |
| req_base | input | 32 | Base register value |
| req_imm | input | 16 | Signed address offset |
| req_dst | input | 5 | Destination register index |
| req_user | input | 1 | Current user-mode bit |
| req_virt | input | 1 | Current virtual-protected-mode bit |
| chk_addr | output | 32 | Effective address of the access being evaluated, for the lookups |
| tlb_hit | input | 1 | A valid translation exists for `chk_addr` |
| zone_block | input | 1 | A no-access zone covers `chk_addr` |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 32 | Memory read address |
| mem_rdata | input | 16 | Memory read data, valid in the strobe cycle |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Result taken at the next edge when valid |
| res_wr_en | output | 1 | Destination register write enable |
| res_dst | output | 5 | Destination register index |
| res_data | output | 32 | Zero-extended load value |
| res_exc | output | 1 | A fault was raised |
| res_cause | output | 5 | Fault cause code |
| res_s | output | 1 | Store flag (always 0 for this load) |
| res_w | output | 1 | Word-size flag (always 0 for halfword) |
| res_diz | output | 1 | Zone-protection flag |
| res_rx | output | 5 | Register index reported for a misaligned access |
| res_mode_wr | output | 1 | The mode and saved-mode bits below are to be written |
| res_user | output | 1 | New user-mode bit |
| res_virt | output | 1 | New virtual-mode bit |
| res_user_sv | output | 1 | New saved user-mode bit |
| res_virt_sv | output | 1 | New saved virtual-mode bit |

## Verification
The hardest cases to reach are the ones where two or three fault conditions hold together, because the lookup results must agree with an address the block computes itself. The bench derives `tlb_hit` and `zone_block` from `chk_addr` by region: the top nibble F means no translation, and E means a blocked zone. It then chooses base, offset and mode bits so that the sum lands in those regions with bit 0 set or cleared. A second hard case is a result stalled while more requests wait behind it. The bench produces this by dropping `res_ready` on a pseudo-random pattern during a burst of mixed requests.

// File: rtl/hw_load_unit.sv
module hw_load_unit #(
  parameter int AREA_MODE = 0,
  parameter int XLEN      = 32,
  parameter int IMM_W     = 16,
  parameter int HALF_W    = 16,
  parameter int RIDX_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [XLEN-1:0]   req_base,
  input  logic [IMM_W-1:0]  req_imm,
  input  logic [RIDX_W-1:0] req_dst,
  input  logic              req_user,
  input  logic              req_virt,
  output logic [XLEN-1:0]   chk_addr,
  input  logic              tlb_hit,
  input  logic              zone_block,
  output logic              mem_rd_en,
  output logic [XLEN-1:0]   mem_addr,
  input  logic [HALF_W-1:0] mem_rdata,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_wr_en,
  output logic [RIDX_W-1:0] res_dst,
  output logic [XLEN-1:0]   res_data,
  output logic              res_exc,
  output logic [4:0]        res_cause,
  output logic              res_s,
  output logic              res_w,
  output logic              res_diz,
  output logic [RIDX_W-1:0] res_rx,
  output logic              res_mode_wr,
  output logic              res_user,
  output logic              res_virt,
  output logic              res_user_sv,
  output logic              res_virt_sv
);
  localparam int LAT = (AREA_MODE == 1) ? 2 : 1;
  localparam logic [4:0] EC_TLB   = 5'b10010;
  localparam logic [4:0] EC_ZONE  = 5'b10000;
  localparam logic [4:0] EC_ALIGN = 5'b00001;

  logic              out_free;
  logic              ev_valid, ev_go;
  logic [XLEN-1:0]   ev_addr;
  logic [RIDX_W-1:0] ev_dst;
  logic              ev_user, ev_virt;
  logic [XLEN-1:0]   req_ea;

  assign out_free = !res_valid || res_ready;
  assign req_ea   = req_base + {{(XLEN-IMM_W){req_imm[IMM_W-1]}}, req_imm};

  generate
    if (LAT == 1) begin : g_lat1
      assign req_ready = out_free;
      assign ev_valid  = req_valid;
      assign ev_addr   = req_ea;
      assign ev_dst    = req_dst;
      assign ev_user   = req_user;
      assign ev_virt   = req_virt;
    end else begin : g_lat2
      logic              s1_v;
      logic [XLEN-1:0]   s1_addr;
      logic [RIDX_W-1:0] s1_dst;
      logic              s1_user, s1_virt;

      assign req_ready = !s1_v || out_free;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       s1_v <= 1'b0;
        else if (req_valid && req_ready)  s1_v <= 1'b1;
        else if (out_free)                s1_v <= 1'b0;
      end

      always_ff @(posedge clk) begin
        if (req_valid && req_ready) begin
          s1_addr <= req_ea;
          s1_dst  <= req_dst;
          s1_user <= req_user;
          s1_virt <= req_virt;
        end
      end

      assign ev_valid = s1_v;
      assign ev_addr  = s1_addr;
      assign ev_dst   = s1_dst;
      assign ev_user  = s1_user;
      assign ev_virt  = s1_virt;
    end
  endgenerate

  logic f_tlb, f_zone, f_align, fault;
  assign f_tlb   = ev_virt && !tlb_hit;
  assign f_zone  = !f_tlb && ev_user && ev_virt && zone_block;
  assign f_align = !f_tlb && !f_zone && ev_addr[0];
  assign fault   = f_tlb || f_zone || f_align;

  assign ev_go     = ev_valid && out_free;
  assign chk_addr  = ev_addr;
  assign mem_addr  = ev_addr;
  assign mem_rd_en = ev_go && !fault;

  logic [4:0] cause_n;
  always_comb begin
    cause_n = 5'b00000;
    if (f_tlb)        cause_n = EC_TLB;
    else if (f_zone)  cause_n = EC_ZONE;
    else if (f_align) cause_n = EC_ALIGN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         res_valid <= 1'b0;
    else if (ev_go)     res_valid <= 1'b1;
    else if (res_ready) res_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (ev_go) begin
      res_wr_en   <= !fault;
      res_dst     <= ev_dst;
      res_data    <= fault ? '0 : {{(XLEN-HALF_W){1'b0}}, mem_rdata};
      res_exc     <= fault;
      res_cause   <= cause_n;
      res_diz     <= f_zone;
      res_rx      <= f_align ? ev_dst : '0;
      res_mode_wr <= f_tlb || f_zone;
      res_user    <= (f_tlb || f_zone) ? 1'b0 : ev_user;
      res_virt    <= (f_tlb || f_zone) ? 1'b0 : ev_virt;
      res_user_sv <= (f_tlb || f_zone) ? ev_user : 1'b0;
      res_virt_sv <= (f_tlb || f_zone) ? ev_virt : 1'b0;
    end
  end

  assign res_s = 1'b0;
  assign res_w = 1'b0;
endmodule

module hw_load_unit_chk #(
  parameter int AREA_MODE = 0,
  parameter int XLEN      = 32,
  parameter int HALF_W    = 16,
  parameter int RIDX_W    = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              mem_rd_en,
  input logic [XLEN-1:0]   mem_addr,
  input logic              res_valid,
  input logic              res_ready,
  input logic              res_wr_en,
  input logic [RIDX_W-1:0] res_dst,
  input logic [XLEN-1:0]   res_data,
  input logic              res_exc,
  input logic [4:0]        res_cause,
  input logic              res_diz,
  input logic [RIDX_W-1:0] res_rx,
  input logic              res_mode_wr,
  input logic              res_user,
  input logic              res_virt
);
  localparam int LAT = (AREA_MODE == 1) ? 2 : 1;

  a_r6_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_wr_en |-> res_data[XLEN-1:HALF_W] == '0 && !res_exc);

  a_r7_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_exc |-> !res_wr_en);

  a_r7_read_even: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !mem_addr[0]);

  a_r8_mode_clear: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_mode_wr |-> !res_user && !res_virt && res_exc);

  a_r4_align_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_exc && res_cause == 5'b00001 |-> !res_mode_wr && res_rx == res_dst);

  a_r3_diz_zone: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_diz |-> res_exc && res_cause == 5'b10000 && res_mode_wr);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_cause)
                                && $stable(res_exc) && $stable(res_dst));

  a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_ready, LAT) |-> res_valid);
endmodule

bind hw_load_unit hw_load_unit_chk #(.AREA_MODE(AREA_MODE), .XLEN(XLEN), .HALF_W(HALF_W), .RIDX_W(RIDX_W)) u_chk (.*);

// File: tb/tb_hw_load_unit.sv
module tb_hw_load_unit;
  localparam int AREA = 1;
  localparam int LAT  = (AREA == 1) ? 2 : 1;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_base = '0;
  logic [15:0] req_imm = '0;
  logic [4:0]  req_dst = '0;
  logic        req_user = 1'b0, req_virt = 1'b0;
  logic [31:0] chk_addr, mem_addr, res_data;
  logic        tlb_hit, zone_block, mem_rd_en;
  logic [15:0] mem_rdata;
  logic        res_valid, res_ready = 1'b1;
  logic        res_wr_en, res_exc, res_s, res_w, res_diz, res_mode_wr;
  logic        res_user, res_virt, res_user_sv, res_virt_sv;
  logic [4:0]  res_dst, res_cause, res_rx;

  always #4 clk = ~clk;

  assign tlb_hit    = chk_addr[31:28] != 4'hF;
  assign zone_block = chk_addr[31:28] == 4'hE;
  assign mem_rdata  = {mem_addr[15:1], 1'b0} ^ 16'hC3A5;

  hw_load_unit #(.AREA_MODE(AREA)) dut (.*);

  typedef struct packed {
    logic        wr; logic [4:0] dst; logic [31:0] data; logic exc; logic [4:0] cause;
    logic        s; logic w; logic diz; logic [4:0] rx;
    logic        mwr; logic u; logic v; logic usv; logic vsv;
  } res_t;
  typedef struct packed { res_t r; int acc; logic lat_chk; logic [2:0] kind; logic multi; } item_t;

  item_t q[$];
  int checks = 0, errors = 0, cyc = 0, rd_cnt = 0, ok_cnt = 0;
  logic bp = 1'b0, done = 1'b0;
  logic [31:0] lfsr = 32'hACE1_2345;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && mem_rd_en) rd_cnt <= rd_cnt + 1;
    if (rst_n && mem_rd_en && mem_addr[0]) begin
      checks++; errors++;
      $display("FAIL R7 read with odd address actual=%h expected=even", mem_addr);
    end
  end

  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    res_ready <= bp ? lfsr[3] : 1'b1;
  end

  task automatic send(input logic [31:0] b, input logic [15:0] im, input logic [4:0] d,
                      input logic u, input logic v);
    item_t it;
    logic [31:0] ea;
    logic tlb, zon, odd, ft, fz, fa;
    ea  = b + {{16{im[15]}}, im};
    tlb = v && ea[31:28] == 4'hF;
    zon = u && v && ea[31:28] == 4'hE;
    odd = ea[0];
    ft = tlb; fz = !ft && zon; fa = !ft && !fz && odd;
    it = '0;
    it.multi = (int'(tlb) + int'(zon) + int'(odd)) > 1;
    it.kind  = ft ? 3'd2 : fz ? 3'd3 : fa ? 3'd4 : 3'd6;
    it.r.wr  = !(ft || fz || fa);
    it.r.dst = d;
    it.r.data = it.r.wr ? {16'h0, {ea[15:1], 1'b0} ^ 16'hC3A5} : 32'h0;
    it.r.exc = ft || fz || fa;
    it.r.cause = ft ? 5'b10010 : fz ? 5'b10000 : fa ? 5'b00001 : 5'b00000;
    it.r.diz = fz;
    it.r.rx  = fa ? d : 5'd0;
    it.r.mwr = ft || fz;
    it.r.u   = (ft || fz) ? 1'b0 : u;
    it.r.v   = (ft || fz) ? 1'b0 : v;
    it.r.usv = (ft || fz) ? u : 1'b0;
    it.r.vsv = (ft || fz) ? v : 1'b0;
    it.lat_chk = !bp;
    if (it.r.wr) ok_cnt++;
    @(negedge clk);
    req_valid = 1'b1; req_base = b; req_imm = im; req_dst = d; req_user = u; req_virt = v;
    #3;
    while (!req_ready) begin @(negedge clk); #3; end
    it.acc = cyc;
    q.push_back(it);
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk); req_valid = 1'b0;
  endtask

  res_t held;
  logic stalled = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (stalled) begin
        checks++;
        if (!res_valid || res_data != held.data || res_cause != held.cause || res_dst != held.dst
            || res_exc != held.exc) begin
          errors++;
          $display("FAIL R10 stalled result changed actual=%h/%h expected=%h/%h",
                   res_data, res_cause, held.data, held.cause);
        end
      end
      stalled = res_valid && !res_ready;
      held = {res_wr_en, res_dst, res_data, res_exc, res_cause, res_s, res_w, res_diz, res_rx,
              res_mode_wr, res_user, res_virt, res_user_sv, res_virt_sv};
      if (res_valid && res_ready) begin
        item_t it;
        string tag;
        checks++;
        if (q.size() == 0) begin
          errors++;
          $display("FAIL R10 unexpected result actual=%h expected=none", held);
        end else begin
          it = q.pop_front();
          case (it.kind)
            3'd2: tag = "R2 R8";
            3'd3: tag = "R3 R8";
            3'd4: tag = "R4";
            default: tag = "R1 R6 R7";
          endcase
          if (it.multi) tag = {"R5 ", tag};
          if (held != it.r) begin
            errors++;
            $display("FAIL %s result actual=%h expected=%h", tag, held, it.r);
          end
          if (it.lat_chk) begin
            checks++;
            if (cyc != it.acc + LAT) begin
              errors++;
              $display("FAIL R9 latency actual=%0d expected=%0d", cyc - it.acc, LAT);
            end
          end
        end
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (res_valid !== 1'b0 || mem_rd_en !== 1'b0) begin
      errors++;
      $display("FAIL R11 reset state actual=%b%b expected=00", res_valid, mem_rd_en);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (req_ready !== 1'b1) begin
      errors++;
      $display("FAIL R11 ready after reset actual=%b expected=1", req_ready);
    end
    // directed, back to back, result port always ready
    send(32'h0000_1000, 16'h0010, 5'd3, 1'b1, 1'b1);   // R6 plain load
    send(32'h0000_2000, 16'hFFFE, 5'd4, 1'b0, 1'b0);   // R1 negative offset
    send(32'hF000_0000, 16'h0020, 5'd5, 1'b0, 1'b1);   // R2
    send(32'hF000_0000, 16'h0020, 5'd6, 1'b1, 1'b0);   // virt off: no miss
    send(32'hE000_0010, 16'h0000, 5'd7, 1'b1, 1'b1);   // R3
    send(32'hE000_0010, 16'h0000, 5'd8, 1'b0, 1'b1);   // R3 needs user mode
    send(32'h0000_1001, 16'h0000, 5'd9, 1'b1, 1'b1);   // R4
    send(32'hF000_0001, 16'h0000, 5'd10, 1'b1, 1'b1);  // R5 miss over all
    send(32'hE000_0003, 16'h0000, 5'd11, 1'b1, 1'b1);  // R5 zone over align
    send(32'hE000_0003, 16'h0000, 5'd12, 1'b0, 1'b1);  // align only
    send(32'h0000_0000, 16'h8000, 5'd13, 1'b0, 1'b0);  // R1 sign extension
    send(32'hFFFF_FFFF, 16'h0003, 5'd14, 1'b0, 1'b0);  // R1 wrap
    idle();
    repeat (4) @(negedge clk);
    // R10: pseudo-random back-pressure with mixed requests
    bp = 1'b1;
    for (int i = 0; i < 60; i++) begin
      logic [31:0] b;
      b = {lfsr[7:6] == 2'b11 ? 4'hF : lfsr[5:4] == 2'b11 ? 4'hE : 4'h1, lfsr[27:0]};
      send(b, lfsr[23:8], lfsr[12:8], lfsr[13], lfsr[14]);
      if (lfsr[2]) idle();
    end
    idle();
    bp = 1'b0;
    repeat (12) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R10 results missing actual=%0d expected=0", q.size());
    end
    checks++;
    if (rd_cnt != ok_cnt) begin
      errors++;
      $display("FAIL R7 read strobes actual=%0d expected=%0d", rd_cnt, ok_cnt);
    end
    finish_run();
  end
endmodule